// File: doc/BRIEF.md
# Prescaled 64-bit Time Base with Tear-Free Capture

A free-running 64-bit up counter that software reaches through a plain 32-bit register read/write port. A programmable divider sets the rate: the count advances once every D+1 clock cycles, where D is a 16-bit field in the control word. Software may read the live count directly. Because a 64-bit value cannot be read in one access without tearing, a command bit in the control word copies all 64 bits into a capture pair in a single cycle. Both halves of that pair then stay fixed until the next capture command.

A second command combination replaces the count with a 64-bit start value that software first stages in two load words. The commands act only on the cycle of the control write. The stored control word reads back exactly as written. Reads are combinational from the read address. Writes take effect at the clock edge on which the write strobe is sampled.

Register layout (byte offsets): control 0x00, live count low/high 0x04/0x08, load value low/high 0x0C/0x10, captured count low/high 0x14/0x18. Control bits [31:16] hold D. Bits [1:0] hold the command: 2'b01 captures and 2'b11 loads. Any other value issues no command.

Top module: `ctr64_snapshot_timer`

## Requirements
- R1: While reset is asserted and at its release, the control word, live count, load words and captured count all read zero, so D is zero.
- R2: With no load command, the live count advances by exactly one on every (D+1)-th cycle and holds otherwise. D is control bits [31:16], and a carry out of the low word propagates into the high word.
- R3: A control write with bits [1:0] = 2'b01 copies the count held just before that write edge into the capture pair. Read at any later time, the high half and the low half both come from that single copy.
- R4: A control write with bits [1:0] = 2'b11 makes the live count equal the 64-bit load value on the cycle after the write, restarts the divider, and then counts up from there.
- R5: The control word reads back as written. A command takes effect once only: the captured count stays unchanged in the cycles after a capture while the live count keeps moving.
- R6: Writing the load words changes the load readback but not the live count until a load command is issued.
- R7: The count wraps from all ones to zero with no other effect.
- R8: A control write with bits [1:0] = 2'b10 or 2'b00 neither loads nor captures.
- R9: Writes to the live count and capture addresses are ignored, and reads of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_addr | input | 8 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Byte offset of the read |
| rd_data | output | 32 | Read data, combinational from rd_addr |

## Verification
A divider that drifts by one state shows up at the live count word within D+1 cycles, as an increment that comes early or late. The per-cycle comparison against the reference model catches it on that edge. A capture taken one edge off, or a capture that is refreshed again later, leaves the captured words differing from the count that the bench recorded at the command. A wrong load priority or a missing divider restart shifts every later increment, so it is visible in the first read after the load and in each divider period after that.

// File: rtl/ctr64_pkg.sv
package ctr64_pkg;
  // register byte offsets; word i of a wide register sits at base + 4*i
  localparam logic [7:0] OFS_CTRL      = 8'h00;
  localparam int         BASE_LIVE     = 4;
  localparam int         WORD_STRIDE   = 4;
  // command encodings in control bits [1:0]
  localparam logic [1:0] CMD_CAPTURE   = 2'b01;
  localparam logic [1:0] CMD_LOAD      = 2'b11;

  typedef struct packed {
    logic capture;
    logic load;
  } ctr_cmd_t;
endpackage

// File: rtl/ctr64_prescaler.sv
module ctr64_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  input  logic             restart_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] pre_q, pre_d;
  logic             pre_en;

  assign tick_o = (pre_q >= div_i) && !restart_i;
  assign pre_en = 1'b1;

  always_comb begin
    pre_d = pre_q + 1'b1;
    if (restart_i || tick_o) pre_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (pre_en) pre_q <= pre_d;
  end

  // R2
  pre_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart_i && !tick_o) |=> (pre_q == DIV_W'($past(pre_q) + 1'b1)));
  // R4
  pre_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (pre_q == '0));
endmodule

// File: rtl/ctr64_core.sv
module ctr64_core #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load_i || tick_i;

  always_comb begin
    if (load_i) cnt_d = load_val_i;
    else        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R4
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_val_i)));
  // R2
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ((cnt_q == $past(cnt_q)) || (cnt_q == CNT_W'($past(cnt_q) + 1'b1))));
  // R7
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && tick_i && (cnt_q == {CNT_W{1'b1}})) |=> (cnt_q == '0));
endmodule

// File: rtl/ctr64_regs.sv
module ctr64_regs
  import ctr64_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 64,
  parameter int DIV_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [DIV_W-1:0]  div_o,
  output ctr_cmd_t          cmd_o,
  output logic [CNT_W-1:0]  load_val_o
);
  localparam int NWORD     = CNT_W / DATA_W;
  localparam int BASE_LOAD = BASE_LIVE + WORD_STRIDE * NWORD;
  localparam int BASE_SNAP = BASE_LOAD + WORD_STRIDE * NWORD;
  localparam int DIV_LSB   = DATA_W - DIV_W;

  logic [DATA_W-1:0] ctrl_q;
  logic              ctrl_en;
  logic [CNT_W-1:0]  load_q;
  logic [CNT_W-1:0]  snap_q;
  logic              snap_en;
  logic [NWORD-1:0]  load_en;

  assign ctrl_en       = wr_en && (wr_addr == ADDR_W'(OFS_CTRL));
  assign cmd_o.capture = ctrl_en && (wr_data[1:0] == CMD_CAPTURE);
  assign cmd_o.load    = ctrl_en && (wr_data[1:0] == CMD_LOAD);
  assign snap_en       = cmd_o.capture;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       snap_q <= '0;
    else if (snap_en) snap_q <= cnt_i;
  end

  for (genvar w = 0; w < NWORD; w++) begin : g_load
    assign load_en[w] = wr_en && (wr_addr == ADDR_W'(BASE_LOAD + WORD_STRIDE * w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          load_q[w*DATA_W +: DATA_W] <= '0;
      else if (load_en[w]) load_q[w*DATA_W +: DATA_W] <= wr_data;
    end
  end

  assign div_o      = ctrl_q[DIV_LSB +: DIV_W];
  assign load_val_o = load_q;

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(OFS_CTRL)) rd_data = ctrl_q;
    for (int w = 0; w < NWORD; w++) begin
      if (rd_addr == ADDR_W'(BASE_LIVE + WORD_STRIDE * w)) rd_data = cnt_i[w*DATA_W +: DATA_W];
      if (rd_addr == ADDR_W'(BASE_LOAD + WORD_STRIDE * w)) rd_data = load_q[w*DATA_W +: DATA_W];
      if (rd_addr == ADDR_W'(BASE_SNAP + WORD_STRIDE * w)) rd_data = snap_q[w*DATA_W +: DATA_W];
    end
  end

  // R3
  snap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snap_en |=> (snap_q == $past(cnt_i)));
  // R5
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_en |=> $stable(snap_q));
  // R5
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> $stable(ctrl_q));
  // R8
  cmd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cmd_o.capture, cmd_o.load}) <= 1);
endmodule

// File: rtl/ctr64_snapshot_timer.sv
module ctr64_snapshot_timer
  import ctr64_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 64,
  parameter int DIV_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DIV_W-1:0] div;
  ctr_cmd_t         cmd;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt;
  logic             tick;

  ctr64_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .cnt_i     (cnt),
    .div_o     (div),
    .cmd_o     (cmd),
    .load_val_o(load_val)
  );

  ctr64_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .div_i    (div),
    .restart_i(cmd.load),
    .tick_o   (tick)
  );

  ctr64_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick),
    .load_i    (cmd.load),
    .load_val_i(load_val),
    .cnt_o     (cnt)
  );
endmodule

// File: tb/ctr64_snapshot_timer_bench.sv
`timescale 1ns/100ps
module ctr64_snapshot_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit live   = 0;

  // behavioural reference state
  longint unsigned m_cnt = 0, m_load = 0, m_snap = 0;
  int unsigned     m_ctrl = 0, m_pre = 0;

  always #2 clk = ~clk; // 250 MHz

  ctr64_snapshot_timer u_ctr64_snapshot_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_load = 0; m_snap = 0; m_ctrl = 0; m_pre = 0;
    end else begin
      longint unsigned old_cnt;
      int unsigned     old_div;
      bit do_load, do_snap;
      old_cnt = m_cnt;
      old_div = m_ctrl >> 16;
      do_load = 0; do_snap = 0;
      live    = 1;
      if (wr_en) begin
        case (wr_addr)
          8'h00: begin
            m_ctrl  = wr_data;
            do_load = (wr_data[1:0] == 2'b11);
            do_snap = (wr_data[1:0] == 2'b01);
          end
          8'h0C: m_load = {m_load[63:32], wr_data};
          8'h10: m_load = {wr_data, m_load[31:0]};
          default: ;
        endcase
      end
      if (do_load) begin
        m_cnt = m_load; m_pre = 0;
      end else if (m_pre >= old_div) begin
        m_cnt = old_cnt + 1; m_pre = 0;
      end else begin
        m_pre = m_pre + 1;
      end
      if (do_snap) m_snap = old_cnt;
    end
  end

  function automatic logic [31:0] mread(input logic [7:0] a);
    case (a)
      8'h00: return m_ctrl;
      8'h04: return m_cnt[31:0];
      8'h08: return m_cnt[63:32];
      8'h0C: return m_load[31:0];
      8'h10: return m_load[63:32];
      8'h14: return m_snap[31:0];
      8'h18: return m_snap[63:32];
      default: return 32'h0;
    endcase
  endfunction

  // per-cycle comparison against the reference model (R2 and the rest by address)
  always @(negedge clk) begin
    #1.5;
    if (live && !done) begin
      checks++;
      if (rd_data !== mread(rd_addr)) begin
        fails++;
        $display("FAIL R2 model addr %h: actual %h expected %h", rd_addr, rd_data, mread(rd_addr));
      end
    end
  end

  task automatic chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    rd_addr = a;
    #0.4;
    checks++;
    if (rd_data !== exp) begin
      fails++;
      $display("FAIL %s addr %h: actual %h expected %h", req, a, rd_data, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      rd_addr = 8'(4 * (i % 8));
      @(negedge clk);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(8'h00, 32'h0, "R1");
    chk(8'h04, 32'h0, "R1");
    chk(8'h14, 32'h0, "R1");
    rst_n = 1'b1;
    // R4 load with D=3
    wr(8'h0C, 32'h100);
    wr(8'h10, 32'h0);
    wr(8'h00, 32'h0003_0003);
    chk(8'h04, 32'h100, "R4");
    chk(8'h08, 32'h0, "R4");
    chk(8'h00, 32'h0003_0003, "R5");
    idle(3);
    chk(8'h04, 32'h100, "R2");
    idle(1);
    chk(8'h04, 32'h101, "R2");
    idle(4);
    chk(8'h04, 32'h102, "R2");
    // R6 staging does not touch the count
    wr(8'h0C, 32'h5555);
    chk(8'h04, 32'h102, "R6");
    chk(8'h0C, 32'h5555, "R6");
    // R3 capture
    wr(8'h00, 32'h0003_0001);
    chk(8'h14, 32'h102, "R3");
    chk(8'h18, 32'h0, "R3");
    chk(8'h00, 32'h0003_0001, "R5");
    idle(10);
    chk(8'h04, 32'h105, "R5");
    chk(8'h14, 32'h102, "R5");
    // R8 bit1 alone: no load, no capture
    wr(8'h00, 32'h0003_0002);
    chk(8'h04, 32'h105, "R8");
    chk(8'h14, 32'h102, "R8");
    // R7 wrap
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h00, 32'h0000_0003);
    chk(8'h04, 32'hFFFF_FFFF, "R4");
    chk(8'h08, 32'hFFFF_FFFF, "R4");
    idle(1);
    chk(8'h04, 32'h0, "R7");
    chk(8'h08, 32'h0, "R7");
    // R3 tear-free capture across a carry
    wr(8'h0C, 32'hFFFF_FFF0);
    wr(8'h10, 32'h7);
    wr(8'h00, 32'h0000_0003);
    wr(8'h00, 32'h0000_0001);
    idle(20);
    chk(8'h18, 32'h7, "R3");
    chk(8'h14, 32'hFFFF_FFF0, "R3");
    chk(8'h08, 32'h8, "R2");
    idle(1);
    // R9 read-only and unmapped
    wr(8'h04, 32'hDEAD);
    chk(8'h04, 32'h7, "R9");
    chk(8'h1C, 32'h0, "R9");
    wr(8'h14, 32'h0);
    chk(8'h14, 32'hFFFF_FFF0, "R9");
    // R2 divider change to D=1, R8 with bits [1:0]=00
    wr(8'h00, 32'h0001_0000);
    chk(8'h04, 32'h9, "R2");
    chk(8'h14, 32'hFFFF_FFF0, "R8");
    idle(1);
    chk(8'h04, 32'h9, "R2");
    idle(1);
    chk(8'h04, 32'hA, "R2");
    idle(50);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule